// File: doc/BRIEF.md
# Prefix-Extended Index Register Unit

This unit holds two 16-bit index registers and executes the index-register instructions that carry an 8-bit immediate: load of the low byte, add of a signed byte, and compare against a byte. A separate one-instruction prefix lets these instructions take a full 16-bit operand. The prefix writes an 8-bit extension byte and raises a one-shot extension flag. If the next instruction is one of the six index operations, that instruction uses the extension byte as its upper operand byte.

Fetch and decode sit outside the unit. Each decoded instruction arrives as an operation code, a register select and an immediate, qualified by a one-cycle strobe. The register values and the carry and zero flags are registered. They reflect an instruction one cycle after the clock edge that accepts it.

For compare, the operand is formed by adding a complement. When the prefix is used, the software must therefore place the ones' complement of the wanted high byte in the extension register.

Top module: `idx_ext_unit`

## Requirements
- R1: A synchronous active-high reset clears both index registers, the carry and zero flags, the extension byte and the extension flag.
- R2: Operation code 1 (set extension) stores the immediate as the extension byte and raises the extension flag. It leaves both index registers and the carry and zero flags unchanged.
- R3: Any strobed operation other than code 1 clears the extension flag after it executes, whether or not it used the flag. A cycle without the strobe leaves the flag and the extension byte unchanged.
- R4: Operation code 2 (low-byte load) with the flag raised writes {extension, immediate} into the whole selected register. Extension 0x15 with immediate 0x7D gives 0x157D.
- R5: Code 2 without the flag replaces bits 7:0 of the selected register with the immediate and keeps bits 15:8. Code 2 never changes the carry or zero flag.
- R6: Operation code 3 (add) with the flag raised adds {extension, immediate} to the selected register. Extension 0xB8 with immediate 0x4F adds 0xB84F.
- R7: Code 3 without the flag adds the immediate sign-extended to 16 bits.
- R8: Code 3 sets carry to the carry out of bit 15 of the sum and sets zero when the 16-bit result is zero.
- R9: Operation code 4 (compare) computes register + {hi, ~immediate} + 1, where hi is the extension byte when the flag is raised and 0xFF otherwise. It sets carry to the carry out of bit 15 and zero to whether the sum is zero, and discards the sum. Extension 0xE6 with immediate 0xA2 compares against 0x19A2.
- R10: Register select 0 addresses X and select 1 addresses Y. The register that is not selected never changes.
- R11: Codes 0, 5, 6 and 7 change no register and no flag other than clearing the extension flag (R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe: one instruction this cycle |
| op_code | input | 3 | Decoded operation (1 set extension, 2 load low, 3 add, 4 compare) |
| reg_sel | input | 1 | Index register select (0 = X, 1 = Y) |
| imm | input | 8 | Instruction immediate |
| x_out | output | 16 | X register value |
| y_out | output | 16 | Y register value |
| carry_out | output | 1 | Carry flag |
| zero_out | output | 1 | Zero flag |

## Verification
The assertions assume that every op_code, reg_sel and imm value sampled with op_valid high belongs to one instruction. They also assume that the extension flag is meant to be consumed only by the strobed operation that directly follows the prefix, with any number of strobe-free cycles in between. The stimulus drives every input on the falling clock edge, so each input is stable at the sampling edge. It mixes back-to-back prefixes, idle gaps after a prefix, unused codes and random operations on both registers, all inside that contract.

// File: rtl/idx_ext_pkg.sv
package idx_ext_pkg;
  localparam int IMM_W   = 8;
  localparam int DATA_W  = 2 * IMM_W;
  localparam int NUM_IDX = 2;
  localparam int SEL_W   = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_SETEXT = 3'd1,
    OP_LDLO   = 3'd2,
    OP_ADDI   = 3'd3,
    OP_CMPI   = 3'd4
  } op_e;
endpackage

// File: rtl/idx_ext_prefix.sv
module idx_ext_prefix #(
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [IMM_W-1:0] imm,
  output logic [IMM_W-1:0] ext_q,
  output logic             armed
);
  import idx_ext_pkg::*;

  logic is_set;
  assign is_set = (op_code == OP_SETEXT);

  // one-shot arming: set by the prefix, dropped by any other instruction
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= '0;
      armed <= 1'b0;
    end else if (op_valid) begin
      armed <= is_set;
      if (is_set) ext_q <= imm;
    end
  end
endmodule

// File: rtl/idx_ext_operand.sv
module idx_ext_operand #(
  parameter int IMM_W  = 8,
  parameter int DATA_W = 2 * IMM_W
) (
  input  logic [2:0]        op_code,
  input  logic              armed,
  input  logic [IMM_W-1:0]  ext_q,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] cur,
  output logic [DATA_W-1:0] add_b,
  output logic              add_cin,
  output logic [DATA_W-1:0] ld_val
);
  import idx_ext_pkg::*;

  localparam int HI_W = DATA_W - IMM_W;

  logic [HI_W-1:0] sign_hi;
  logic [HI_W-1:0] hi_byte;
  assign sign_hi = {HI_W{imm[IMM_W-1]}};

  always_comb begin
    hi_byte = '0;
    add_b   = '0;
    add_cin = 1'b0;
    unique case (op_code)
      OP_CMPI: begin
        hi_byte = armed ? HI_W'(ext_q) : '1;
        add_b   = {hi_byte, ~imm};
        add_cin = 1'b1;
      end
      default: begin
        hi_byte = armed ? HI_W'(ext_q) : sign_hi;
        add_b   = {hi_byte, imm};
        add_cin = 1'b0;
      end
    endcase
  end

  assign ld_val = armed ? {HI_W'(ext_q), imm} : {cur[DATA_W-1:IMM_W], imm};
endmodule

// File: rtl/idx_ext_alu.sv
module idx_ext_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              zero
);
  logic [DATA_W:0] wide;
  assign wide = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
  assign sum  = wide[DATA_W-1:0];
  assign cout = wide[DATA_W];
  assign zero = (sum == '0);
endmodule

// File: rtl/idx_ext_bank.sv
module idx_ext_bank #(
  parameter int DATA_W  = 16,
  parameter int NUM_IDX = 2,
  parameter int SEL_W   = 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [SEL_W-1:0]               rd_sel,
  output logic [DATA_W-1:0]              rd_data,
  output logic [NUM_IDX-1:0][DATA_W-1:0] regs_q
);
  for (genvar i = 0; i < NUM_IDX; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs_q[i] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(i))) regs_q[i] <= wr_data;
    end
  end

  assign rd_data = regs_q[rd_sel];
endmodule

// File: rtl/idx_ext_unit.sv
module idx_ext_unit
  import idx_ext_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic              reg_sel,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] x_out,
  output logic [DATA_W-1:0] y_out,
  output logic              carry_out,
  output logic              zero_out
);
  logic [IMM_W-1:0]               ext_q;
  logic                           armed;
  logic [DATA_W-1:0]              cur, add_b, ld_val, sum;
  logic                           add_cin, cout, zero;
  logic                           wr_en;
  logic [DATA_W-1:0]              wr_data;
  logic [NUM_IDX-1:0][DATA_W-1:0] regs_q;
  logic [SEL_W-1:0]               sel;

  assign sel = SEL_W'(reg_sel);

  idx_ext_prefix #(.IMM_W(IMM_W)) u_prefix (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .imm(imm), .ext_q(ext_q), .armed(armed)
  );

  idx_ext_operand #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_operand (
    .op_code(op_code), .armed(armed), .ext_q(ext_q), .imm(imm), .cur(cur),
    .add_b(add_b), .add_cin(add_cin), .ld_val(ld_val)
  );

  idx_ext_alu #(.DATA_W(DATA_W)) u_alu (
    .a(cur), .b(add_b), .cin(add_cin), .sum(sum), .cout(cout), .zero(zero)
  );

  always_comb begin
    wr_en   = 1'b0;
    wr_data = sum;
    if (op_valid) begin
      unique case (op_code)
        OP_LDLO: begin wr_en = 1'b1; wr_data = ld_val; end
        OP_ADDI: begin wr_en = 1'b1; wr_data = sum;    end
        default: wr_en = 1'b0;
      endcase
    end
  end

  idx_ext_bank #(.DATA_W(DATA_W), .NUM_IDX(NUM_IDX), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(sel), .wr_data(wr_data),
    .rd_sel(sel), .rd_data(cur), .regs_q(regs_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_out <= 1'b0;
      zero_out  <= 1'b0;
    end else if (op_valid && (op_code == OP_ADDI || op_code == OP_CMPI)) begin
      carry_out <= cout;
      zero_out  <= zero;
    end
  end

  assign x_out = regs_q[0];
  assign y_out = regs_q[1];
endmodule

// File: rtl/idx_ext_unit_chk.sv
module idx_ext_unit_chk
  import idx_ext_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic              reg_sel,
  input logic [IMM_W-1:0]  imm,
  input logic [DATA_W-1:0] x_out,
  input logic [DATA_W-1:0] y_out,
  input logic              carry_out,
  input logic              zero_out,
  input logic [IMM_W-1:0]  ext_q,
  input logic              armed
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (x_out == '0 && y_out == '0 && !carry_out && !zero_out && !armed));

  // R2
  set_ext_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SETEXT) |=>
      ($stable(x_out) && $stable(y_out) && $stable(carry_out) && $stable(zero_out) && armed));

  // R3
  disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code != OP_SETEXT) |=> !armed);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(armed) && $stable(ext_q)));

  // R4
  ext_load_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_LDLO && armed && !reg_sel) |=>
      x_out == {$past(ext_q), $past(imm)});

  // R5
  plain_load_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_LDLO && !armed && !reg_sel) |=>
      (x_out[DATA_W-1:IMM_W] == $past(x_out[DATA_W-1:IMM_W]) && x_out[IMM_W-1:0] == $past(imm)
       && $stable(carry_out) && $stable(zero_out)));

  // R8
  add_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ADDI && !reg_sel) |=> (zero_out == (x_out == '0)));

  // R9
  cmp_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CMPI) |=> ($stable(x_out) && $stable(y_out)));

  // R10
  y_sel_keeps_x_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && reg_sel) |=> $stable(x_out));

  // R11
  unused_code_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code > OP_CMPI) |=>
      ($stable(x_out) && $stable(y_out) && $stable(carry_out) && $stable(zero_out)));
endmodule

bind idx_ext_unit idx_ext_unit_chk u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .reg_sel(reg_sel),
  .imm(imm), .x_out(x_out), .y_out(y_out), .carry_out(carry_out),
  .zero_out(zero_out), .ext_q(ext_q), .armed(armed)
);

// File: tb/idx_ext_unit_tb.sv
module idx_ext_unit_tb;
  localparam logic [2:0] C_NOP = 3'd0, C_SET = 3'd1, C_LD = 3'd2, C_ADD = 3'd3, C_CMP = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic reg_sel = 1'b0;
  logic [7:0] imm = '0;
  logic [15:0] x_out, y_out;
  logic carry_out, zero_out;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  logic [15:0] mreg [2];
  logic [7:0]  mext;
  bit          marm, mc, mz;

  always #2 clk = ~clk;

  idx_ext_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .reg_sel(reg_sel),
    .imm(imm), .x_out(x_out), .y_out(y_out), .carry_out(carry_out), .zero_out(zero_out)
  );

  task automatic check16(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    check16(req, "x", x_out, mreg[0]);
    check16(req, "y", y_out, mreg[1]);
    check16(req, "carry", {15'd0, carry_out}, {15'd0, mc});
    check16(req, "zero", {15'd0, zero_out}, {15'd0, mz});
  endtask

  task automatic model(logic [2:0] c, logic s, logic [7:0] i);
    logic [16:0] w;
    logic [15:0] b;
    case (c)
      C_SET: mext = i;
      C_LD:  mreg[s] = marm ? {mext, i} : {mreg[s][15:8], i};
      C_ADD: begin
        b = marm ? {mext, i} : {{8{i[7]}}, i};
        w = {1'b0, mreg[s]} + {1'b0, b};
        mreg[s] = w[15:0]; mc = w[16]; mz = (w[15:0] == 16'h0);
      end
      C_CMP: begin
        b = marm ? {mext, ~i} : {8'hFF, ~i};
        w = {1'b0, mreg[s]} + {1'b0, b} + 17'd1;
        mc = w[16]; mz = (w[15:0] == 16'h0);
      end
      default: ;
    endcase
    marm = (c == C_SET);
  endtask

  task automatic do_op(logic [2:0] c, logic s, logic [7:0] i, string req);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; reg_sel = s; imm = i;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    model(c, s, i);
    compare_all(req);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      compare_all("R3");
    end
  endtask

  initial begin : watchdog
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mreg[0] = '0; mreg[1] = '0; mext = '0; marm = 0; mc = 0; mz = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 compare_all("R1");

    // R5 plain load keeps high byte
    do_op(C_LD, 0, 8'h34, "R5");
    check16("R5", "x literal", x_out, 16'h0034);
    // R4 extended load
    do_op(C_SET, 0, 8'h15, "R2");
    do_op(C_LD, 0, 8'h7D, "R4");
    check16("R4", "x literal", x_out, 16'h157D);
    do_op(C_LD, 0, 8'h01, "R3");
    check16("R3", "flag consumed", x_out, 16'h1501);
    // R6 extended add
    do_op(C_SET, 1, 8'h00, "R2");
    do_op(C_LD, 1, 8'h00, "R10");
    do_op(C_SET, 1, 8'hB8, "R2");
    do_op(C_ADD, 1, 8'h4F, "R6");
    check16("R6", "y literal", y_out, 16'hB84F);
    check16("R10", "x untouched", x_out, 16'h1501);
    // R7 plain add with negative immediate
    do_op(C_ADD, 1, 8'hFF, "R7");
    check16("R7", "y literal", y_out, 16'hB84E);
    check16("R8", "carry", {15'd0, carry_out}, 16'd1);
    // R8 wrap to zero
    do_op(C_SET, 0, 8'hEA, "R2");
    do_op(C_ADD, 0, 8'hFF, "R8");
    check16("R8", "zero flag", {15'd0, zero_out}, 16'd1);
    // R9 compare equal 0x19A2
    do_op(C_SET, 0, 8'h19, "R2");
    do_op(C_LD, 0, 8'hA2, "R4");
    do_op(C_SET, 0, 8'hE6, "R2");
    do_op(C_CMP, 0, 8'hA2, "R9");
    check16("R9", "zero eq", {15'd0, zero_out}, 16'd1);
    check16("R9", "carry eq", {15'd0, carry_out}, 16'd1);
    check16("R9", "x kept", x_out, 16'h19A2);
    // R9 plain compare: 0x19A2 vs 0xA3 -> no zero, carry set
    do_op(C_CMP, 0, 8'hA3, "R9");
    check16("R9", "zero ne", {15'd0, zero_out}, 16'd0);
    // R3 idle gap keeps flag; R11 unused code clears it
    do_op(C_SET, 0, 8'h42, "R2");
    idle(4);
    do_op(C_LD, 0, 8'h10, "R3");
    check16("R3", "held flag", x_out, 16'h4210);
    do_op(C_SET, 0, 8'h77, "R2");
    do_op(3'd6, 0, 8'h55, "R11");
    do_op(C_LD, 0, 8'h11, "R11");
    check16("R11", "flag cleared", x_out, 16'h4211);
    do_op(C_NOP, 1, 8'h00, "R11");

    for (int n = 0; n < 400; n++) begin
      logic [2:0] c;
      c = ($urandom_range(0, 3) == 0) ? C_SET : 3'($urandom_range(0, 7));
      do_op(c, 1'($urandom_range(0, 1)), 8'($urandom), "R10");
    end

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    mreg[0] = '0; mreg[1] = '0; mext = '0; marm = 0; mc = 0; mz = 0;
    compare_all("R1");
    do_op(C_LD, 0, 8'h05, "R1");
    check16("R1", "flag clear after reset", x_out, 16'h0005);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule